// File: doc/BRIEF.md
# Sinc Interpolator and One-Bit Noise-Shaping Modulator

This block turns a slow stream of 16-bit signed audio samples into a one-bit stream at the fixed high rate of 1.728 MHz. The high rate is given by a one-cycle tick enable, `hr_tick`. Each sample is held in a register. Once per frame of R high-rate ticks, a second-order sinc (CIC) interpolator takes in the held sample. The interpolator has comb stages at the frame rate and integrators at the tick rate, so it draws a straight line from the previous sample to the new one across the frame. R is 45, 54 or 60 for input rates of 38.4, 32.0 and 28.8 kHz. A constant reciprocal then scales the interpolator result back to unit gain.

A second-order modulator follows the interpolator. It has two saturating accumulators and plus or minus full-scale feedback, and it reduces each interpolated value to one bit per tick. The one-density of the stream follows the input level.

A small two-state controller orders the start-up. The states are ST_IDLE and ST_RUN, with one transition, ST_IDLE to ST_RUN, taken on the first valid sample. In ST_IDLE the output toggles on every tick, which is the code for zero, and all filter and modulator state is held cleared. In ST_RUN the modulator drives the output. Only reset returns the controller to ST_IDLE. A sample that is not refreshed is reused in every later frame.

Top module: `sinc_sdm_dac`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `bit_out` and `bit_tick` are 0. The controller is in ST_IDLE and every comb, integrator and modulator register is zero.
- R2: `bit_tick` is high for exactly the one clock that follows a clock where `hr_tick` was high. `bit_out` changes only on the clock edge that samples `hr_tick` high.
- R3: In ST_IDLE, each tick inverts `bit_out`, so the first tick after reset gives 1, then 0, 1, 0 and so on.
- R4: The first clock with `smp_vld` high moves the controller from ST_IDLE to ST_RUN. No input causes the reverse transition; only reset does.
- R5: `smp_in` is captured only on clocks where `smp_vld` is high. At all other times it is ignored, and the last captured sample is reused in every frame until a new one arrives.
- R6: `rate_sel` picks the frame length R: 2'b00 gives 45 ticks, 2'b01 gives 54 ticks, and 2'b10 and 2'b11 both give 60 ticks. The code is sampled at the first tick of each frame.
- R7: The interpolator is a second-order CIC (zero-stuffed, two combs, two integrators). Its value is multiplied by K and shifted right by 16, with K = round(65536/R): 1456, 1214 or 1092. A constant input x therefore settles to about x at every rate.
- R8: For a constant input x, the fraction of ones in the stream is (x + 32768) / 65536, within 2 % over 3000 ticks, at every rate.
- R9: The modulator emits 1 when its second accumulator is non-negative, and feeds back +32768 for a 1 and -32768 for a 0. With a zero input, the first ticks in ST_RUN produce the repeating pattern 1, 0, 0, 1.
- R10: Both modulator accumulators (20 bits by default) clamp at plus or minus (2^19 - 1) and never wrap. An input of +32767 yields at least 90 % ones and -32768 at most 10 % ones.
- R11: The integrators carry guard bits, so a full-scale input at R = 60 settles without overflow and the density stays on the side of the input's sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 16 | Signed input sample |
| smp_vld | input | 1 | Sample strobe; captures `smp_in` |
| rate_sel | input | 2 | Frame length code (R6) |
| hr_tick | input | 1 | 1.728 MHz tick enable, one clock wide |
| bit_out | output | 1 | One-bit modulated stream |
| bit_tick | output | 1 | Marks the clock in which a new `bit_out` is presented |

## Verification
Each bit is due one clock after the clock that carries `hr_tick`. The bench raises the tick at a falling edge, lowers it at the next falling edge, and reads `bit_out` and `bit_tick` there, which is the first point after the sampling edge. The interpolator and modulator take one tick each, and the CIC ramp spans one frame. Density checks therefore wait 240 ticks (at least four frames at R = 60) before counting ones over 3000 ticks. The exact start-up patterns of R3 and R9 are compared tick by tick from the first tick after reset or after the first sample.

// File: rtl/sinc_sdm_pkg.sv
package sinc_sdm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;

    typedef enum logic [1:0] {
        RATE_R45 = 2'b00,
        RATE_R54 = 2'b01,
        RATE_R60 = 2'b10,
        RATE_ALT = 2'b11
    } rate_code_t;

    localparam int MAX_RATIO = 60;

    function automatic int unsigned ratio_of(input logic [1:0] code);
        int unsigned r;
        unique case (rate_code_t'(code))
            RATE_R45: r = 45;
            RATE_R54: r = 54;
            RATE_R60: r = 60;
            RATE_ALT: r = 60;
            default:  r = 60;
        endcase
        return r;
    endfunction

    // Rounded reciprocal of the frame length in 2^shift units.
    function automatic int unsigned recip_of(input logic [1:0] code, input int unsigned shift);
        int unsigned r;
        r = ratio_of(code);
        return ((32'd1 << shift) + (r >> 1)) / r;
    endfunction

endpackage

// File: rtl/sinc_sdm_ctrl.sv
module sinc_sdm_ctrl
    import sinc_sdm_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int PH_W   = 6,
    parameter int CODE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hr_tick,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic [CODE_W-1:0]       rate_sel,
    output logic                    run,
    output logic                    frame_start,
    output logic                    idle_bit,
    output logic signed [SMP_W-1:0] hold_q,
    output logic [CODE_W-1:0]       code_q
);

    ctl_state_t        state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [PH_W-1:0]   ratio_q;
    logic              tgl_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and decoded outputs
    always_comb begin
        state_d     = state_q;
        run         = 1'b0;
        frame_start = 1'b0;
        idle_bit    = ~tgl_q;
        unique case (state_q)
            ST_IDLE: begin
                if (smp_vld) state_d = ST_RUN;
            end
            ST_RUN: begin
                run         = 1'b1;
                frame_start = hr_tick && (phase_q == '0);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sample hold: only a strobe changes it
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (smp_vld) hold_q <= smp_in;
    end

    // Frame phase and per-frame rate latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            ratio_q <= PH_W'(ratio_of(2'b10));
            code_q  <= CODE_W'(2'b10);
        end else if (!run) begin
            phase_q <= '0;
            ratio_q <= PH_W'(ratio_of(rate_sel));
            code_q  <= rate_sel;
        end else if (hr_tick) begin
            if (phase_q == '0) begin
                ratio_q <= PH_W'(ratio_of(rate_sel));
                code_q  <= rate_sel;
            end
            if (phase_q == ratio_q - PH_W'(1)) phase_q <= '0;
            else                               phase_q <= phase_q + PH_W'(1);
        end
    end

    // Idle zero pattern
    always_ff @(posedge clk) begin
        if (!rst_n)                tgl_q <= 1'b0;
        else if (!run && hr_tick)  tgl_q <= ~tgl_q;
    end

endmodule

// File: rtl/sinc_sdm_cic.sv
module sinc_sdm_cic
    import sinc_sdm_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int INT_W  = 24,
    parameter int K_W    = 12,
    parameter int SHIFT  = 16,
    parameter int CODE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    hr_tick,
    input  logic                    frame_start,
    input  logic signed [SMP_W-1:0] hold_q,
    input  logic [CODE_W-1:0]       code_q,
    output logic signed [SMP_W-1:0] interp_q
);

    localparam int C1_W = SMP_W + 1;
    localparam int C2_W = SMP_W + 2;
    localparam int P_W  = INT_W + K_W + 1;
    localparam logic signed [P_W-1:0] OUT_HI = P_W'((2 ** (SMP_W - 1)) - 1);
    localparam logic signed [P_W-1:0] OUT_LO = -P_W'(2 ** (SMP_W - 1));

    logic signed [SMP_W-1:0] x1_q;
    logic signed [C1_W-1:0]  c1, c1_q;
    logic signed [C2_W-1:0]  c2;
    logic signed [INT_W-1:0] i1_q, i2_q, inj;
    logic [K_W-1:0]          k_val;
    logic signed [P_W-1:0]   prod, scaled;
    logic signed [SMP_W-1:0] sat_v;

    // Comb section, evaluated at the frame rate
    always_comb begin
        c1  = {hold_q[SMP_W-1], hold_q} - {x1_q[SMP_W-1], x1_q};
        c2  = {c1[C1_W-1], c1} - {c1_q[C1_W-1], c1_q};
        inj = frame_start ? {{(INT_W - C2_W){c2[C2_W-1]}}, c2} : '0;
    end

    // Gain normalisation by rounded reciprocal, then clamp
    always_comb begin
        k_val  = K_W'(recip_of(code_q, SHIFT));
        prod   = i2_q * $signed({1'b0, k_val});
        scaled = prod >>> SHIFT;
        if (scaled > OUT_HI)      sat_v = OUT_HI[SMP_W-1:0];
        else if (scaled < OUT_LO) sat_v = OUT_LO[SMP_W-1:0];
        else                      sat_v = scaled[SMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            x1_q     <= '0;
            c1_q     <= '0;
            i1_q     <= '0;
            i2_q     <= '0;
            interp_q <= '0;
        end else if (hr_tick) begin
            if (frame_start) begin
                x1_q <= hold_q;
                c1_q <= c1;
            end
            i1_q     <= i1_q + inj;
            i2_q     <= i2_q + i1_q;
            interp_q <= sat_v;
        end
    end

endmodule

// File: rtl/sinc_sdm_mod.sv
module sinc_sdm_mod #(
    parameter int SMP_W = 16,
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    hr_tick,
    input  logic signed [SMP_W-1:0] u,
    output logic                    y,
    output logic signed [ACC_W-1:0] acc1_q,
    output logic signed [ACC_W-1:0] acc2_q
);

    localparam int EW = ACC_W + 2;
    localparam logic signed [EW-1:0] LIM    = EW'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [EW-1:0] FB_POS = EW'(2 ** (SMP_W - 1));
    localparam logic signed [EW-1:0] FB_NEG = -FB_POS;

    logic signed [EW-1:0]    fb, s1, s2;
    logic signed [ACC_W-1:0] a1_n, a2_n;

    function automatic logic signed [ACC_W-1:0] clamp(input logic signed [EW-1:0] v);
        if (v > LIM)       return LIM[ACC_W-1:0];
        else if (v < -LIM) return (-LIM) & {{(EW-ACC_W){1'b0}}, {ACC_W{1'b1}}};
        else               return v[ACC_W-1:0];
    endfunction

    always_comb begin
        y    = ~acc2_q[ACC_W-1];
        fb   = y ? FB_POS : FB_NEG;
        s1   = {{(EW-ACC_W){acc1_q[ACC_W-1]}}, acc1_q}
             + {{(EW-SMP_W){u[SMP_W-1]}}, u} - fb;
        a1_n = clamp(s1);
        s2   = {{(EW-ACC_W){acc2_q[ACC_W-1]}}, acc2_q}
             + {{(EW-ACC_W){a1_n[ACC_W-1]}}, a1_n} - fb;
        a2_n = clamp(s2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc1_q <= '0;
            acc2_q <= '0;
        end else if (hr_tick) begin
            acc1_q <= a1_n;
            acc2_q <= a2_n;
        end
    end

endmodule

// File: rtl/sinc_sdm_dac.sv
module sinc_sdm_dac
    import sinc_sdm_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int ACC_W  = 20,
    parameter int K_W    = 12,
    parameter int SHIFT  = 16,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp_in,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              hr_tick,
    output logic              bit_out,
    output logic              bit_tick
);

    localparam int PH_W  = $clog2(MAX_RATIO + 1);
    localparam int INT_W = SMP_W + $clog2(MAX_RATIO) + 2;

    logic                    run_w, frame_w, idle_w, mod_y;
    logic signed [SMP_W-1:0] hold_w, interp_w;
    logic [CODE_W-1:0]       code_w;
    logic signed [ACC_W-1:0] acc1_w, acc2_w;

    sinc_sdm_ctrl #(.SMP_W(SMP_W), .PH_W(PH_W), .CODE_W(CODE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hr_tick     (hr_tick),
        .smp_vld     (smp_vld),
        .smp_in      ($signed(smp_in)),
        .rate_sel    (rate_sel),
        .run         (run_w),
        .frame_start (frame_w),
        .idle_bit    (idle_w),
        .hold_q      (hold_w),
        .code_q      (code_w)
    );

    sinc_sdm_cic #(.SMP_W(SMP_W), .INT_W(INT_W), .K_W(K_W), .SHIFT(SHIFT), .CODE_W(CODE_W)) u_cic (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (!run_w),
        .hr_tick     (hr_tick),
        .frame_start (frame_w),
        .hold_q      (hold_w),
        .code_q      (code_w),
        .interp_q    (interp_w)
    );

    sinc_sdm_mod #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!run_w),
        .hr_tick (hr_tick),
        .u       (interp_w),
        .y       (mod_y),
        .acc1_q  (acc1_w),
        .acc2_q  (acc2_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= hr_tick;
            if (hr_tick) bit_out <= run_w ? mod_y : idle_w;
        end
    end

endmodule

// File: rtl/sinc_sdm_dac_chk.sv
module sinc_sdm_dac_chk #(
    parameter int SMP_W = 16,
    parameter int ACC_W = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    hr_tick,
    input logic                    smp_vld,
    input logic                    bit_out,
    input logic                    bit_tick,
    input logic                    run,
    input logic signed [SMP_W-1:0] hold,
    input logic signed [ACC_W-1:0] acc1,
    input logic signed [ACC_W-1:0] acc2
);

    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    assert_reset_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!bit_out && !bit_tick && !run));

    assert_tick_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(hr_tick));

    assert_bit_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hr_tick |=> $stable(bit_out));

    assert_idle_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && hr_tick) |=> (bit_out != $past(bit_out)));

    assert_run_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    assert_hold_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(hold));

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc1 != ACC_MIN) && (acc2 != ACC_MIN));

endmodule

bind sinc_sdm_dac sinc_sdm_dac_chk #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hr_tick  (hr_tick),
    .smp_vld  (smp_vld),
    .bit_out  (bit_out),
    .bit_tick (bit_tick),
    .run      (run_w),
    .hold     (hold_w),
    .acc1     (acc1_w),
    .acc2     (acc2_w)
);

// File: tb/sinc_sdm_dac_bench.sv
module sinc_sdm_dac_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] smp_in = '0;
    logic        smp_vld = 1'b0;
    logic [1:0]  rate_sel = 2'b00;
    logic        hr_tick = 1'b0;
    logic        bit_out, bit_tick;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sinc_sdm_dac u_sinc_sdm_dac (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (smp_in),
        .smp_vld  (smp_vld),
        .rate_sel (rate_sel),
        .hr_tick  (hr_tick),
        .bit_out  (bit_out),
        .bit_tick (bit_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; hr_tick = 1'b0; smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_tick(output logic b, output logic t);
        @(negedge clk) hr_tick = 1'b1;
        @(negedge clk) hr_tick = 1'b0;
        b = bit_out;
        t = bit_tick;
    endtask

    task automatic load_sample(input logic [15:0] x);
        @(negedge clk);
        smp_in = x; smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        smp_in  = 16'h8000;   // garbage that must be ignored
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(bit_out == 1'b0, "R1", "bit_out in reset", bit_out, 0);
        check(bit_tick == 1'b0, "R1", "bit_tick in reset", bit_tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bit_out == 1'b0, "R1", "bit_out after reset", bit_out, 0);
    endtask

    // R2, R3
    task automatic t_idle();
        logic b, t, prev;
        apply_reset();
        for (int i = 0; i < 6; i++) begin
            do_tick(b, t);
            check(b == ((i % 2) == 0), "R3", "idle pattern bit", b, ((i % 2) == 0));
            check(t == 1'b1, "R2", "bit_tick after tick", t, 1);
        end
        prev = bit_out;
        @(negedge clk);
        check(bit_tick == 1'b0, "R2", "bit_tick without tick", bit_tick, 0);
        check(bit_out == prev, "R2", "bit_out steady without tick", bit_out, prev);
    endtask

    // R4, R9
    task automatic t_start_pattern();
        logic b, t;
        int exp;
        apply_reset();
        load_sample(16'h0000);
        for (int i = 0; i < 8; i++) begin
            do_tick(b, t);
            exp = ((i % 4) == 0 || (i % 4) == 3) ? 1 : 0;
            check(b == exp[0], "R9", "run start pattern (R4 entry)", b, exp);
        end
    endtask

    function automatic int expect_ones(input int x, input int win);
        return (win * (x + 32768)) / 65536;
    endfunction

    task automatic run_density(input logic [1:0] rate, input int x, output int ones);
        logic b, t;
        apply_reset();
        rate_sel = rate;
        load_sample(16'(x));
        repeat (240) do_tick(b, t);
        ones = 0;
        for (int i = 0; i < 3000; i++) begin
            do_tick(b, t);
            if (b) ones++;
        end
    endtask

    // R5, R6, R7, R8
    task automatic t_density(input logic [1:0] rate, input int x, input string req);
        int ones, exp;
        run_density(rate, x, ones);
        exp = expect_ones(x, 3000);
        check((ones >= exp - 60) && (ones <= exp + 60), req, "ones count", ones, exp);
    endtask

    // R10, R11
    task automatic t_full_scale();
        int ones;
        run_density(2'b10, 32767, ones);
        check(ones >= 2700, "R10", "ones at +full scale (R11 guard)", ones, 2700);
        run_density(2'b10, -32768, ones);
        check(ones <= 300, "R11", "ones at -full scale (R10 clamp)", ones, 300);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_start_pattern();
        t_density(2'b00, 0,      "R8");
        t_density(2'b01, 0,      "R8");
        t_density(2'b10, 0,      "R8");
        t_density(2'b00, 16384,  "R7");
        t_density(2'b01, 16384,  "R5");
        t_density(2'b10, -16384, "R7");
        t_density(2'b00, 8000,   "R6");
        t_density(2'b11, -16384, "R6");
        t_full_scale();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule